// File: doc/BRIEF.md
# Byte-to-Halfword Cell Packer

This block takes a stream of 9-bit cell bytes (eight data bits plus one side bit). Each byte carries a valid strobe, and the first byte of a cell is marked by a start-of-cell flag. The block regroups the bytes into 18-bit words made of two byte lanes. The low lane is bits [8:0] and the high lane is bits [17:9]. In a narrow mode it instead passes each byte straight through on the low lane. A cell of any size between 8 and 128 bytes can be carried. When a cell has an odd number of bytes, the block pads the last word with a zero byte.

An edit mode adjusts a cell as it passes through. In transmit mode it removes the fifth byte of every cell. In receive mode it adds a zero byte right after the fifth byte. This lets 53-byte cells meet the 54-byte layout used on a 16-bit interface. A swap control picks which lane carries the earlier byte of each pair, and a change to it shows on the very next output word. Every output word is registered, and a start-of-cell flag comes out with the word that holds the cell's first byte.

Top module: `cellpack_top`

## Requirements
- R1: While reset is asserted and after it is released with no input, `out_valid` and `out_soc` are low.
- R2: A cell opens only on an accepted byte with `in_soc` high while no cell is open, and `cell_size` is captured at that moment. Bytes that arrive while no cell is open and `in_soc` is low are discarded. `in_soc` has no effect inside an open cell. The cell closes after `cell_size` bytes. Supported sizes are 8 to 128, or 8 to 126 when editing is enabled.
- R3: With `bus_narrow` high, every accepted cell byte appears on `out_word[8:0]` with `out_word[17:9]` zero. No byte is added, removed or padded, and `swap_hi` and `edit_en` have no effect.
- R4: With `bus_narrow` low and `edit_en` low, the cell bytes are emitted in consecutive pairs, one word per pair.
- R5: In the wide mode, if the edited cell holds an odd number of bytes, its last byte is paired with a zero pad byte that takes the second position of the pair.
- R6: With `edit_en` high and `tx_mode` high, the fifth byte of each cell (index 4 counting from 0) is removed. An even size therefore ends with a pad byte, and an odd size ends without one.
- R7: With `edit_en` high and `tx_mode` low, a zero byte is inserted right after the fifth byte, so it becomes byte six. An even size therefore ends with a pad byte, and an odd size ends without one.
- R8: With `swap_hi` low, the first byte of a pair sits in the low lane and the second in the high lane. With `swap_hi` high, the first byte sits in the high lane and the second in the low lane.
- R9: The lane order of a word follows the `swap_hi` value sampled on the same clock edge that registers the word. A change of `swap_hi` therefore shows on the next output word, even within a cell.
- R10: `out_soc` is high exactly on the word that carries the first byte of a cell, once per cell, and only while `out_valid` is high.
- R11: A word appears on the cycle after the clock edge that accepts the byte completing it. In the wide mode, a byte that is inserted or used as padding completes its word together with the byte that triggered it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte strobe |
| in_soc | input | 1 | Marks the first byte of a cell |
| in_byte | input | 9 | Input byte with its side bit |
| cell_size | input | 8 | Cell length in bytes, captured at cell start |
| bus_narrow | input | 1 | 1: 9-bit pass-through output, 0: 18-bit paired output |
| edit_en | input | 1 | Enables removal or insertion at the fifth byte |
| tx_mode | input | 1 | 1: transmit (remove), 0: receive (insert) |
| swap_hi | input | 1 | 1: first byte of a pair in the high lane |
| out_valid | output | 1 | Output word strobe |
| out_soc | output | 1 | Output word carries the cell's first byte |
| out_word | output | 18 | Output word, low lane [8:0], high lane [17:9] |

## Verification
The bench covers each combination of edit mode and size parity. A packer that applies the pad to the wrong parity produces one word too many or one too few. A packer that edits at the wrong index shifts every later byte into the wrong lane. A misplaced insertion or deletion breaks the pairing of every word that follows it. The bench toggles the swap control on every byte within a cell, so a swap that is registered one stage too late or too early shows as reversed lanes. The bench also feeds stray bytes before the start of a cell, a repeated start flag in the middle of a cell, and idle gaps. A sequencer that reopens a cell on a repeated start, or that counts stray bytes, emits words it should not.

// File: rtl/cellpack_pkg.sv
package cellpack_pkg;
    localparam int BYTE_W   = 9;
    localparam int SIZE_W   = 8;
    localparam int WORD_W   = 2 * BYTE_W;
    localparam int EDIT_POS = 4;

    typedef struct packed {
        logic              active;
        logic [SIZE_W-1:0] idx;
        logic [SIZE_W-1:0] size;
    } seq_t;

    typedef struct packed {
        logic              have;
        logic [BYTE_W-1:0] held;
        logic              first;
        logic              ovalid;
        logic              osoc;
        logic              onarrow;
        logic [BYTE_W-1:0] fb;
        logic [BYTE_W-1:0] sb;
        logic              swap;
    } pack_t;
endpackage

// File: rtl/cellpack_seq.sv
module cellpack_seq
    import cellpack_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_soc,
    input  logic [SIZE_W-1:0] cell_size,
    output logic              acc,
    output logic              first_byte,
    output logic              last_byte,
    output logic [SIZE_W-1:0] cur_idx,
    output logic              active_o,
    output logic [SIZE_W-1:0] idx_o,
    output logic [SIZE_W-1:0] size_o
);
    seq_t s_d, s_q;
    logic [SIZE_W-1:0] size_eff;

    always_comb begin
        s_d        = s_q;
        size_eff   = s_q.active ? s_q.size : cell_size;
        cur_idx    = s_q.active ? s_q.idx : '0;
        acc        = in_valid && (s_q.active || in_soc);
        first_byte = !s_q.active;
        last_byte  = (cur_idx == size_eff - SIZE_W'(1));
        if (acc) begin
            if (last_byte) begin
                s_d.active = 1'b0;
                s_d.idx    = '0;
            end else begin
                s_d.active = 1'b1;
                s_d.idx    = cur_idx + SIZE_W'(1);
                s_d.size   = size_eff;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign active_o = s_q.active;
    assign idx_o    = s_q.idx;
    assign size_o   = s_q.size;
endmodule

// File: rtl/cellpack_pair.sv
module cellpack_pair
    import cellpack_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic              first_byte,
    input  logic              last_byte,
    input  logic [SIZE_W-1:0] cur_idx,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              bus_narrow,
    input  logic              edit_en,
    input  logic              tx_mode,
    input  logic              swap_hi,
    output logic              ovalid,
    output logic              osoc,
    output logic              onarrow,
    output logic [BYTE_W-1:0] fb,
    output logic [BYTE_W-1:0] sb,
    output logic              swap_q
);
    pack_t p_d, p_q;
    logic              have, first, at_edit, emit;
    logic [BYTE_W-1:0] e_fb, e_sb;

    always_comb begin
        p_d        = p_q;
        p_d.ovalid = 1'b0;
        p_d.osoc   = 1'b0;
        p_d.swap   = swap_hi;
        have       = first_byte ? 1'b0 : p_q.have;
        first      = first_byte ? 1'b1 : p_q.first;
        at_edit    = edit_en && (cur_idx == SIZE_W'(EDIT_POS));
        emit       = 1'b0;
        e_fb       = in_byte;
        e_sb       = '0;
        if (acc) begin
            p_d.have  = have;
            p_d.first = first;
            if (bus_narrow) begin
                emit = 1'b1;
            end else if (at_edit && tx_mode) begin
                emit = 1'b0;
            end else if (at_edit) begin
                emit = 1'b1;
            end else if (have) begin
                emit     = 1'b1;
                e_fb     = p_q.held;
                e_sb     = in_byte;
                p_d.have = 1'b0;
            end else if (last_byte) begin
                emit = 1'b1;
            end else begin
                p_d.held = in_byte;
                p_d.have = 1'b1;
            end
            if (emit) begin
                p_d.ovalid  = 1'b1;
                p_d.osoc    = first;
                p_d.first   = 1'b0;
                p_d.fb      = e_fb;
                p_d.sb      = e_sb;
                p_d.onarrow = bus_narrow;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign ovalid  = p_q.ovalid;
    assign osoc    = p_q.osoc;
    assign onarrow = p_q.onarrow;
    assign fb      = p_q.fb;
    assign sb      = p_q.sb;
    assign swap_q  = p_q.swap;
endmodule

// File: rtl/cellpack_lane.sv
module cellpack_lane
    import cellpack_pkg::*;
(
    input  logic              onarrow,
    input  logic              swap_q,
    input  logic [BYTE_W-1:0] fb,
    input  logic [BYTE_W-1:0] sb,
    output logic [WORD_W-1:0] word
);
    always_comb begin
        if (onarrow)     word = {{BYTE_W{1'b0}}, fb};
        else if (swap_q) word = {fb, sb};
        else             word = {sb, fb};
    end
endmodule

// File: rtl/cellpack_top.sv
module cellpack_top
    import cellpack_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_soc,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic [SIZE_W-1:0] cell_size,
    input  logic              bus_narrow,
    input  logic              edit_en,
    input  logic              tx_mode,
    input  logic              swap_hi,
    output logic              out_valid,
    output logic              out_soc,
    output logic [WORD_W-1:0] out_word
);
    logic              acc, first_byte, last_byte;
    logic [SIZE_W-1:0] cur_idx, seq_idx, seq_size;
    logic              seq_active;
    logic              onarrow, swap_q;
    logic [BYTE_W-1:0] fb, sb;

    cellpack_seq u_seq (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_soc(in_soc),
        .cell_size(cell_size), .acc(acc), .first_byte(first_byte),
        .last_byte(last_byte), .cur_idx(cur_idx), .active_o(seq_active),
        .idx_o(seq_idx), .size_o(seq_size)
    );

    cellpack_pair u_pair (
        .clk(clk), .rst_n(rst_n), .acc(acc), .first_byte(first_byte),
        .last_byte(last_byte), .cur_idx(cur_idx), .in_byte(in_byte),
        .bus_narrow(bus_narrow), .edit_en(edit_en), .tx_mode(tx_mode),
        .swap_hi(swap_hi), .ovalid(out_valid), .osoc(out_soc),
        .onarrow(onarrow), .fb(fb), .sb(sb), .swap_q(swap_q)
    );

    cellpack_lane u_lane (
        .onarrow(onarrow), .swap_q(swap_q), .fb(fb), .sb(sb), .word(out_word)
    );
endmodule

// File: rtl/cellpack_chk.sv
module cellpack_chk
    import cellpack_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              bus_narrow,
    input logic              out_valid,
    input logic              out_soc,
    input logic [WORD_W-1:0] out_word,
    input logic              seq_active,
    input logic [SIZE_W-1:0] seq_idx,
    input logic [SIZE_W-1:0] seq_size
);
    assert_soc_with_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_soc |-> out_valid);

    assert_word_follows_byte_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    assert_narrow_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(bus_narrow)) |-> (out_word[WORD_W-1:BYTE_W] == '0));

    assert_index_in_cell_R2: assert property (@(posedge clk) disable iff (!rst_n)
        seq_active |-> (seq_idx < seq_size));

    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_valid);
endmodule

bind cellpack_top cellpack_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .bus_narrow(bus_narrow),
    .out_valid(out_valid), .out_soc(out_soc), .out_word(out_word),
    .seq_active(seq_active), .seq_idx(seq_idx), .seq_size(seq_size)
);

// File: tb/cellpack_top_test.sv
module cellpack_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_soc = 1'b0;
    logic [8:0]  in_byte = '0;
    logic [7:0]  cell_size = 8'd53;
    logic        bus_narrow = 1'b0, edit_en = 1'b0, tx_mode = 1'b0, swap_hi = 1'b0;
    logic        out_valid, out_soc;
    logic [17:0] out_word;

    int n_run = 0, n_fail = 0;
    logic [17:0] cap_w [0:299];
    logic        cap_s [0:299];
    int          cap_n = 0;
    logic [8:0]  eff_v [0:299];
    int          eff_s [0:299];

    always #2.5 clk = ~clk;

    cellpack_top uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_soc(in_soc),
        .in_byte(in_byte), .cell_size(cell_size), .bus_narrow(bus_narrow),
        .edit_en(edit_en), .tx_mode(tx_mode), .swap_hi(swap_hi),
        .out_valid(out_valid), .out_soc(out_soc), .out_word(out_word)
    );

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (cap_n < 300) begin
                cap_w[cap_n] = out_word;
                cap_s[cap_n] = out_soc;
            end
            cap_n = cap_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] byte_at(input int i);
        return {1'(i % 3 == 0), 8'(i * 5 + 17)};
    endfunction

    function automatic bit swap_at(input int mode, input int i);
        if (mode == 2) return 1'(i % 2);
        return 1'(mode);
    endfunction

    task automatic run_cell(input string req, input int size, input bit nar,
                            input bit bdi, input bit tx, input int swm, input bit framing);
        int n = 0;
        int nw;
        logic [17:0] w;
        bit sw;
        for (int i = 0; i < size; i++) begin
            if (!nar && bdi && tx && i == 4) continue;
            eff_v[n] = byte_at(i); eff_s[n] = i; n++;
            if (!nar && bdi && !tx && i == 4) begin
                eff_v[n] = '0; eff_s[n] = i; n++;
            end
        end
        if (!nar && (n % 2 == 1)) begin
            eff_v[n] = '0; eff_s[n] = size - 1; n++;
        end
        cap_n = 0;
        @(negedge clk);
        bus_narrow = nar; edit_en = bdi; tx_mode = tx; cell_size = 8'(size);
        if (framing) begin
            for (int k = 0; k < 3; k++) begin
                in_valid = 1'b1; in_soc = 1'b0; in_byte = 9'h1AA;
                @(negedge clk);
            end
        end
        for (int i = 0; i < size; i++) begin
            in_valid = 1'b1;
            in_soc   = (i == 0) || (framing && i == 10);
            in_byte  = byte_at(i);
            swap_hi  = swap_at(swm, i);
            @(negedge clk);
            if (framing && (i % 4 == 3)) begin
                in_valid = 1'b0; in_soc = 1'b0;
                @(negedge clk);
            end
        end
        in_valid = 1'b0; in_soc = 1'b0;
        repeat (3) @(negedge clk);
        nw = nar ? n : n / 2;
        chk(cap_n == nw, {req, " word count"}, cap_n, nw);
        for (int k = 0; k < nw && k < cap_n; k++) begin
            if (nar) begin
                w = {9'b0, eff_v[k]};
            end else begin
                sw = swap_at(swm, eff_s[2*k+1]);
                w = sw ? {eff_v[2*k], eff_v[2*k+1]} : {eff_v[2*k+1], eff_v[2*k]};
            end
            chk(cap_w[k] == w, {req, " word"}, int'(cap_w[k]), int'(w));
            chk(cap_s[k] == (k == 0), {req, " R10 start flag"}, int'(cap_s[k]), int'(k == 0));
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(out_valid == 1'b0 && out_soc == 1'b0, "R1 idle after reset",
            int'({out_valid, out_soc}), 0);
    endtask

    task automatic t_narrow();      run_cell("R3 narrow",          53, 1, 1, 0, 2, 0); endtask
    task automatic t_even_plain();  run_cell("R4 R8 even swap low", 54, 0, 0, 0, 0, 0); endtask
    task automatic t_odd_plain();   run_cell("R5 R8 odd swap high", 53, 0, 0, 0, 1, 0); endtask
    task automatic t_tx_even();     run_cell("R6 delete even",     54, 0, 1, 1, 1, 0); endtask
    task automatic t_tx_odd();      run_cell("R6 delete odd",      53, 0, 1, 1, 0, 0); endtask
    task automatic t_rx_even();     run_cell("R7 insert even",     54, 0, 1, 0, 1, 0); endtask
    task automatic t_rx_odd();      run_cell("R7 insert odd",      53, 0, 1, 0, 0, 0); endtask
    task automatic t_swap_dyn();    run_cell("R9 dynamic swap",    20, 0, 0, 0, 2, 0); endtask
    task automatic t_framing();     run_cell("R2 R11 framing min", 8,  0, 0, 0, 0, 1); endtask
    task automatic t_max();         run_cell("R2 max size",        128, 0, 0, 0, 1, 1); endtask
    task automatic t_edit_max();    run_cell("R7 insert 126",      126, 0, 1, 0, 2, 0); endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_narrow();
        t_even_plain();
        t_odd_plain();
        t_tx_even();
        t_tx_odd();
        t_rx_even();
        t_rx_odd();
        t_swap_dyn();
        t_framing();
        t_max();
        t_edit_max();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule